// File: doc/BRIEF.md
# SDRAM Raw Command Issue Unit

This unit sits at the front of an SDRAM controller and lets a host drive the memory through its power-up sequence by hand. The host first stores a 3-bit command selector through a one-cycle register write port. While that selector is zero, host accesses to the memory window are handed on unchanged as ordinary accesses. While it is non-zero, the next host write to any address in the window is not handed on. Instead it becomes one command on the SDRAM command bus, and the accepted write is itself the acknowledgement of that command.

For the two mode-register loads, the two bank-address bits are taken from a pair of adjacent host address bits. The pair starts at bit 26 or bit 25, chosen by a geometry input, and moves up by the rank number. The low host address bits become the mode-register value placed on the address lines. The selector stays in force until it is written again, so repeated writes repeat the command. An init sequence that needs several refreshes can therefore issue them with repeated writes.

Top module: `sdram_cmd_issue`

## Requirements
- R1: After reset the selector is 0 (normal), `cmd_valid` and `pass_valid` are low and `host_ready` is high.
- R2: A selector write issues no command by itself. It takes effect from the clock edge after the one that stores it, so a host write on that same storing edge still sees the old selector.
- R3: Selector values 1, 2 and 4 issue NOP, all-bank precharge and auto-refresh, which appear on `cmd_op` as 0, 1 and 2. Values 6 and 7 issue NOP (`cmd_op` 0).
- R4: Selector 3 issues a mode-register load (`cmd_op` 3) and selector 5 issues an extended mode-register load (`cmd_op` 4).
- R5: For `cmd_op` 3 and 4, `cmd_ba[0]` equals host address bit P+rank and `cmd_ba[1]` equals bit P+rank+1. P is 26 when `cfg_geom_sel` is 0 and 25 when it is 1.
- R6: For `cmd_op` 3 and 4, `cmd_ma` equals host address bits [13:0]. For every other command, `cmd_ba` and `cmd_ma` are zero.
- R7: A command is driven for exactly the one cycle after the edge that accepts its host write. `host_ready` is low during that cycle, and a host access presented then is not accepted.
- R8: A host write that triggers a command produces no pass-through access.
- R9: With selector 0, every accepted host access appears on `pass_valid`/`pass_write`/`pass_addr` one cycle later. `host_ready` stays high throughout.
- R10: With a non-zero selector, host reads pass through as in R9 and issue no command.
- R11: The selector persists, so each later host write issues the same command again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Selector register write strobe |
| cfg_mode | input | 3 | Selector value to store |
| cfg_geom_sel | input | 1 | Bank-bit base: 0 selects bit 26, 1 selects bit 25 |
| cfg_rank | input | 1 | Rank offset added to the bank-bit positions |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 32 | Host byte address in the memory window |
| host_ready | output | 1 | Access accepted when high together with host_valid |
| cmd_valid | output | 1 | Command strobe on the SDRAM command bus |
| cmd_op | output | 3 | Command code (0 NOP, 1 precharge all, 2 refresh, 3 mode load, 4 extended mode load) |
| cmd_ba | output | 2 | Bank address for the command |
| cmd_ma | output | 14 | Address-line value for the command |
| pass_valid | output | 1 | Ordinary access handed on |
| pass_write | output | 1 | Direction of the handed-on access |
| pass_addr | output | 32 | Address of the handed-on access |

## Verification
Every result lands one register stage after the edge that accepts the host access. Commands and pass-through accesses are both due in the cycle after the accept edge, and the one-cycle command pulse and low `host_ready` fall in that same cycle. The bench drives on the falling edge and samples on the next falling edge, which is half a cycle after the accept edge. It then samples once more a full cycle later to confirm that the pulse has ended. Selector writes are checked the same way: the cycle after the storing edge must show no command. A host write placed on the storing edge itself must still follow the old selector.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int unsigned MODE_W = 3;
    localparam int unsigned OP_W   = 3;

    localparam logic [MODE_W-1:0] SEL_NORMAL = 3'd0;
    localparam logic [MODE_W-1:0] SEL_NOP    = 3'd1;
    localparam logic [MODE_W-1:0] SEL_PALL   = 3'd2;
    localparam logic [MODE_W-1:0] SEL_LMR    = 3'd3;
    localparam logic [MODE_W-1:0] SEL_REF    = 3'd4;
    localparam logic [MODE_W-1:0] SEL_EMR    = 3'd5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 3'd0,
        OP_PALL = 3'd1,
        OP_REF  = 3'd2,
        OP_LMR  = 3'd3,
        OP_EMR  = 3'd4
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [1:0] ba;
    } cmd_head_t;

    function automatic op_e sel_to_op(input logic [MODE_W-1:0] sel);
        op_e r;
        case (sel)
            SEL_PALL: r = OP_PALL;
            SEL_REF:  r = OP_REF;
            SEL_LMR:  r = OP_LMR;
            SEL_EMR:  r = OP_EMR;
            default:  r = OP_NOP;
        endcase
        return r;
    endfunction

    function automatic logic op_is_mrs(input op_e op);
        return (op == OP_LMR) || (op == OP_EMR);
    endfunction

endpackage

// File: rtl/sdcmd_mode_reg.sv
module sdcmd_mode_reg
    import sdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= SEL_NORMAL;
        else if (we)
            mode_q <= wdata;
    end

    // R2 / R11: the selector only moves on a register write
    assert_mode_held_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(we) |-> $stable(mode_q));

endmodule

// File: rtl/sdcmd_ba_pick.sv
module sdcmd_ba_pick #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned RANK_W = 1,
    parameter int unsigned POS_A  = 26,
    parameter int unsigned POS_B  = 25
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              geom_sel,
    input  logic [RANK_W-1:0] rank,
    output logic [1:0]        ba
);

    localparam int unsigned IDX_W = $clog2(ADDR_W);

    logic [IDX_W-1:0] base_idx;
    logic [IDX_W-1:0] bit_idx;

    always_comb begin
        base_idx = geom_sel ? IDX_W'(POS_B) : IDX_W'(POS_A);
        bit_idx  = base_idx + IDX_W'(rank);
    end

    for (genvar b = 0; b < 2; b++) begin : g_ba
        logic [IDX_W-1:0] idx_b;
        assign idx_b = bit_idx + IDX_W'(b);
        assign ba[b] = addr[idx_b];
    end

endmodule

// File: rtl/sdcmd_issue_stage.sv
module sdcmd_issue_stage
    import sdcmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MA_W   = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              pass,
    input  cmd_head_t         head_in,
    input  logic [MA_W-1:0]   ma_in,
    input  logic              wr_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              cmd_valid,
    output cmd_head_t         head_q,
    output logic [MA_W-1:0]   ma_q,
    output logic              pass_valid,
    output logic              pass_write,
    output logic [ADDR_W-1:0] pass_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid  <= 1'b0;
            head_q     <= '{op: OP_NOP, ba: 2'b00};
            ma_q       <= '0;
            pass_valid <= 1'b0;
            pass_write <= 1'b0;
            pass_addr  <= '0;
        end else begin
            cmd_valid  <= fire;
            pass_valid <= pass;
            if (fire) begin
                head_q <= head_in;
                ma_q   <= ma_in;
            end
            if (pass) begin
                pass_write <= wr_in;
                pass_addr  <= addr_in;
            end
        end
    end

    // R7: a command is a single-cycle strobe
    assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R8: a command cycle never carries a handed-on access
    assert_no_pass_on_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !pass_valid);

    // R6: non-mode-register commands carry zero bank and address
    assert_zero_payload_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !op_is_mrs(head_q.op)) |-> (head_q.ba == 2'b00 && ma_q == '0));

endmodule

// File: rtl/sdram_cmd_issue.sv
module sdram_cmd_issue
    import sdcmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MA_W   = 14,
    parameter int unsigned RANK_W = 1,
    parameter int unsigned POS_A  = 26,
    parameter int unsigned POS_B  = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_geom_sel,
    input  logic [RANK_W-1:0] cfg_rank,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_ready,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [1:0]        cmd_ba,
    output logic [MA_W-1:0]   cmd_ma,
    output logic              pass_valid,
    output logic              pass_write,
    output logic [ADDR_W-1:0] pass_addr
);

    logic [MODE_W-1:0] mode_q;
    logic [1:0]        ba_raw;
    logic              accept;
    logic              fire;
    logic              pass;
    op_e               op_sel;
    cmd_head_t         head_next;
    cmd_head_t         head_q;
    logic [MA_W-1:0]   ma_next;

    sdcmd_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_mode),
        .mode_q (mode_q)
    );

    sdcmd_ba_pick #(
        .ADDR_W (ADDR_W),
        .RANK_W (RANK_W),
        .POS_A  (POS_A),
        .POS_B  (POS_B)
    ) u_ba (
        .addr     (host_addr),
        .geom_sel (cfg_geom_sel),
        .rank     (cfg_rank),
        .ba       (ba_raw)
    );

    always_comb begin
        host_ready = !cmd_valid;
        accept     = host_valid && host_ready;
        fire       = accept && host_write && (mode_q != SEL_NORMAL);
        pass       = accept && !fire;
        op_sel     = sel_to_op(mode_q);
        head_next.op = op_sel;
        head_next.ba = op_is_mrs(op_sel) ? ba_raw : 2'b00;
        ma_next      = op_is_mrs(op_sel) ? host_addr[MA_W-1:0] : '0;
    end

    sdcmd_issue_stage #(
        .ADDR_W (ADDR_W),
        .MA_W   (MA_W)
    ) u_stage (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .pass       (pass),
        .head_in    (head_next),
        .ma_in      (ma_next),
        .wr_in      (host_write),
        .addr_in    (host_addr),
        .cmd_valid  (cmd_valid),
        .head_q     (head_q),
        .ma_q       (cmd_ma),
        .pass_valid (pass_valid),
        .pass_write (pass_write),
        .pass_addr  (pass_addr)
    );

    assign cmd_op = head_q.op;
    assign cmd_ba = head_q.ba;

    // R2: a command only follows an accepted write under a non-normal selector
    assert_cmd_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) |-> $past(host_valid && host_write && mode_q != SEL_NORMAL));

    // R9: a handed-on access only follows an accepted host request
    assert_pass_cause_R9: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> $past(host_valid));

endmodule

// File: tb/sim_sdram_cmd_issue.sv
module sim_sdram_cmd_issue;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_geom_sel = 1'b0;
    logic [0:0]  cfg_rank = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [31:0] host_addr = 32'd0;
    logic        host_ready;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_ba;
    logic [13:0] cmd_ma;
    logic        pass_valid;
    logic        pass_write;
    logic [31:0] pass_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sdram_cmd_issue u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_geom_sel(cfg_geom_sel), .cfg_rank(cfg_rank),
        .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
        .host_ready(host_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ba(cmd_ba), .cmd_ma(cmd_ma), .pass_valid(pass_valid),
        .pass_write(pass_write), .pass_addr(pass_addr)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_op(input int m);
        case (m)
            2: return 1;
            3: return 3;
            4: return 2;
            5: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_ba(input logic [31:0] a, input int g, input int r);
        int p;
        p = (g != 0 ? 25 : 26) + r;
        return int'((a >> p) & 1) + 2 * int'((a >> (p + 1)) & 1);
    endfunction

    task automatic set_mode(input int m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 3'(m);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cmd_valid == 1'b0, "R2 selector write alone", cmd_valid, 0);
    endtask

    // one host access, checked half a cycle and one and a half cycles after accept
    task automatic host_acc(input bit wr, input logic [31:0] a, input int m, input int g, input int r);
        bit fires;
        int op;
        fires = wr && (m != 0);
        op = exp_op(m);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
        if (fires) begin
            chk(cmd_valid == 1'b1, "R7 cmd strobe", cmd_valid, 1);
            chk(host_ready == 1'b0, "R7 ready low", host_ready, 0);
            chk(pass_valid == 1'b0, "R8 no pass", pass_valid, 0);
            if (m == 3 || m == 5) begin
                chk(int'(cmd_op) == op, "R4 mrs op", cmd_op, op);
                chk(int'(cmd_ba) == exp_ba(a, g, r), "R5 bank bits", cmd_ba, exp_ba(a, g, r));
                chk(cmd_ma == a[13:0], "R6 payload", cmd_ma, a[13:0]);
            end else begin
                chk(int'(cmd_op) == op, "R3 op", cmd_op, op);
                chk(cmd_ba == 2'b00 && cmd_ma == 14'd0, "R6 zero payload", {cmd_ba, cmd_ma}, 0);
            end
        end else begin
            chk(cmd_valid == 1'b0, m != 0 ? "R10 read no cmd" : "R9 no cmd", cmd_valid, 0);
            chk(pass_valid == 1'b1 && pass_write == wr && pass_addr == a,
                m != 0 ? "R10 read pass" : "R9 pass", pass_addr, a);
            chk(host_ready == 1'b1, "R9 ready high", host_ready, 1);
        end
        @(negedge clk);
        chk(cmd_valid == 1'b0 && pass_valid == 1'b0 && host_ready == 1'b1,
            "R7 back to idle", {cmd_valid, pass_valid, host_ready}, 3'b001);
    endtask

    initial begin
        logic [31:0] addrs [4];
        addrs[0] = 32'h0400_1234;
        addrs[1] = 32'h0A00_0ABC;
        addrs[2] = 32'h1200_3FFF;
        addrs[3] = 32'h0C00_2001;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_valid == 0 && pass_valid == 0 && host_ready == 1, "R1 reset state",
            {cmd_valid, pass_valid, host_ready}, 3'b001);
        host_acc(1'b1, 32'h0000_0040, 0, 0, 0); // R1: selector is normal after reset

        for (int m = 0; m < 8; m++) begin
            set_mode(m);
            for (int g = 0; g < 2; g++) begin
                for (int r = 0; r < 2; r++) begin
                    cfg_geom_sel = g[0]; cfg_rank = r[0];
                    for (int k = 0; k < 4; k++) host_acc(1'b1, addrs[k] ^ 32'(k * 32'h0100_0000), m, g, r);
                    host_acc(1'b0, addrs[r], m, g, r);
                end
            end
        end

        // R11: repeated writes under one selector each fire
        set_mode(4);
        for (int i = 0; i < 3; i++) host_acc(1'b1, 32'(i * 16), 4, 0, 0);

        // R7: access presented during the command cycle is not accepted
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = 32'h10;
        @(negedge clk);
        host_addr = 32'h20;
        chk(host_ready == 1'b0, "R7 blocked ready", host_ready, 0);
        @(negedge clk);
        host_valid = 1'b0;
        chk(cmd_valid == 1'b0 && pass_valid == 1'b0, "R7 blocked not accepted",
            {cmd_valid, pass_valid}, 0);

        // R2: a write on the storing edge still sees the old selector
        set_mode(0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 3'd3;
        host_valid = 1'b1; host_write = 1'b1; host_addr = 32'h0400_0005;
        @(negedge clk);
        cfg_we = 1'b0; host_valid = 1'b0;
        chk(pass_valid == 1'b1 && cmd_valid == 1'b0, "R2 old selector on storing edge",
            {pass_valid, cmd_valid}, 2'b10);
        cfg_geom_sel = 1'b0; cfg_rank = 1'b0;
        host_acc(1'b1, 32'h0400_0005, 3, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule